// File: doc/BRIEF.md
# Interrupt Pin Servicing Engine

This block sits behind the input pins of an I/O interrupt controller and decides, pin by pin, when a delivery request goes out toward the processors. Each pin has a routing entry that holds a vector, a destination, a destination mode, a delivery mode, a trigger type and a mask. The engine samples the pin levels into an interrupt request register (IRR) every cycle. It turns rising requests into delivery requests on a valid/ready stream, with the lowest pin index first.

Edge-type pins deliver once for each new rising request. Level-type pins use a remote-IRR handshake: once a request is accepted, remote-IRR is set and further assertions are coalesced. An end-of-interrupt (EOI) broadcast that carries a matching vector clears it. If the pin is still asserted and unmasked at that point, it is serviced again. A per-pin counter spots interrupt storms: when too many immediate re-deliveries follow one another, the next one is handed to a single deferral timer. When that timer expires, it sweeps every eligible level pin.

Top module: `irq_pin_engine`

## Requirements
- R1: After reset every entry is masked, `dlv_valid` is 0 and `remote_irr` is all zero. A pin raised before any entry is written produces no delivery.
- R2: An unmasked edge-type pin (entry bit 12 = 0) raises one delivery request on each 0-to-1 change of its level. Holding the level high adds nothing, and several rising changes made before the request is accepted merge into a single delivery.
- R3: A masked entry (bit 13 = 1) is never delivered. A request that is still pending when its entry is rewritten as masked is dropped.
- R4: A level-type pin (bit 12 = 1) that rises while its remote-IRR is clear is delivered. Its `remote_irr` bit is 1 from the cycle after the request is accepted.
- R5: A level-type pin that is asserted again while its remote-IRR is set is coalesced: no delivery is made and remote-IRR stays set.
- R6: An EOI whose vector matches a level-type entry clears that pin's remote-IRR. If the pin's IRR bit is set and the entry is unmasked, the pin is delivered again. An EOI for a vector that matches no level-type entry changes nothing.
- R7: Each pin counts its successive EOI re-deliveries. The EOI that would bring the count to STORM_LIMIT does not re-deliver; it clears the count and arms the deferral timer instead. An EOI that does not re-deliver the pin also clears the count.
- R8: The armed timer expires DEFER_CYCLES cycles after the EOI that armed it. It then requests service for every unmasked level-type pin whose IRR bit is set and whose remote-IRR is clear. Only one timer is in flight at a time.
- R9: Writing an entry clears that pin's remote-IRR. If the new entry is level-type and unmasked and the pin's IRR bit is set, the write also starts a service attempt; with the pin low it starts none.
- R10: Pending requests leave one per accepted handshake, lowest pin index first, and a request stays presented while `dlv_ready` is low.
- R11: A delivery carries the chosen entry's fields. The entry layout is: vector in bits 7:0, delivery mode in bits 10:8, destination mode in bit 11, trigger type in bit 12, mask in bit 13 and destination in bits 21:14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_level | input | NPINS | Current level of each interrupt pin |
| ent_wr | input | 1 | Write strobe for one routing entry |
| ent_pin | input | PIN_W | Pin whose entry is written |
| ent_data | input | ENT_W | New entry contents (layout in R11) |
| eoi_valid | input | 1 | EOI broadcast strobe |
| eoi_vector | input | VEC_W | Vector carried by the EOI |
| dlv_valid | output | 1 | A delivery request is presented |
| dlv_ready | input | 1 | Downstream accepts the request |
| dlv_pin | output | PIN_W | Pin index of the request |
| dlv_vector | output | VEC_W | Vector of the request |
| dlv_dest | output | DEST_W | Destination of the request |
| dlv_dest_mode | output | 1 | Destination mode of the request |
| dlv_del_mode | output | 3 | Delivery mode of the request |
| dlv_level | output | 1 | 1 when the request comes from a level-type entry |
| remote_irr | output | NPINS | Remote-IRR state of each pin |

## Verification
The stimulus covers several cases. A single edge pin is held high, and repeated rising changes are made while the stream is stalled; together these separate true edge detection from level following and from double counting. Three pins raised in the same cycle under back-pressure expose the issue order. Level pins are retoggled while remote-IRR is set, and EOIs are sent with the pin high, with the pin low, with a foreign vector and with an edge entry's vector; this sorts coalescing from re-delivery and keeps EOIs from acting on the wrong entry. Runs of EOI re-deliveries are sent up to the storm limit, once straight and once broken by a low pin. They show both the deferral with its exact expiry cycle and the counter clearing.

// File: rtl/irq_pin_engine.sv
module irq_pin_engine #(
  parameter int NPINS        = 8,
  parameter int VEC_W        = 8,
  parameter int DEST_W       = 8,
  parameter int STORM_LIMIT  = 10000,
  parameter int DEFER_CYCLES = 2000000,
  localparam int PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1,
  localparam int ENT_W = VEC_W + DEST_W + 6,
  localparam int CNT_W = $clog2(STORM_LIMIT + 1),
  localparam int TMR_W = $clog2(DEFER_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_level,
  input  logic              ent_wr,
  input  logic [PIN_W-1:0]  ent_pin,
  input  logic [ENT_W-1:0]  ent_data,
  input  logic              eoi_valid,
  input  logic [VEC_W-1:0]  eoi_vector,
  output logic              dlv_valid,
  input  logic              dlv_ready,
  output logic [PIN_W-1:0]  dlv_pin,
  output logic [VEC_W-1:0]  dlv_vector,
  output logic [DEST_W-1:0] dlv_dest,
  output logic              dlv_dest_mode,
  output logic [2:0]        dlv_del_mode,
  output logic              dlv_level,
  output logic [NPINS-1:0]  remote_irr
);

  logic [VEC_W-1:0]  vec   [NPINS];
  logic [DEST_W-1:0] dest  [NPINS];
  logic [2:0]        dmod  [NPINS];
  logic [CNT_W-1:0]  storm [NPINS];
  logic [NPINS-1:0]  dsel, lvl, masked, irr, pend, rirr;
  logic              tmr_on;
  logic [TMR_W-1:0]  tmr;

  wire [VEC_W-1:0]  w_vec   = ent_data[VEC_W-1:0];
  wire [2:0]        w_del   = ent_data[VEC_W+2:VEC_W];
  wire              w_dsel  = ent_data[VEC_W+3];
  wire              w_lvl   = ent_data[VEC_W+4];
  wire              w_mask  = ent_data[VEC_W+5];
  wire [DEST_W-1:0] w_dest  = ent_data[ENT_W-1:VEC_W+6];

  wire [NPINS-1:0] rise  = pin_level & ~irr;
  wire             fire  = dlv_valid & dlv_ready;
  wire             sweep = tmr_on && (tmr == TMR_W'(DEFER_CYCLES - 1));

  logic [NPINS-1:0] issued, wr_sel, eoi_hit, eoi_retry, storm_hit, ev;

  always_comb begin
    dlv_pin = '0;
    for (int i = NPINS - 1; i >= 0; i--)
      if (pend[i]) dlv_pin = PIN_W'(i);
  end

  assign dlv_valid     = |pend;
  assign dlv_vector    = vec[dlv_pin];
  assign dlv_dest      = dest[dlv_pin];
  assign dlv_dest_mode = dsel[dlv_pin];
  assign dlv_del_mode  = dmod[dlv_pin];
  assign dlv_level     = lvl[dlv_pin];
  assign remote_irr    = rirr;
  assign issued        = fire ? (NPINS'(1) << dlv_pin) : '0;

  always_comb begin
    for (int i = 0; i < NPINS; i++) begin
      wr_sel[i]    = ent_wr && (ent_pin == PIN_W'(i));
      eoi_hit[i]   = eoi_valid && lvl[i] && (vec[i] == eoi_vector);
      eoi_retry[i] = eoi_hit[i] && !masked[i] && irr[i];
      storm_hit[i] = eoi_retry[i] && (storm[i] + CNT_W'(1) == CNT_W'(STORM_LIMIT));
      ev[i] = (rise[i] && !lvl[i])
            || (!(issued[i] && lvl[i]) &&
                ((rise[i] && lvl[i] && !rirr[i])
                 || (eoi_retry[i] && !storm_hit[i])
                 || (sweep && lvl[i] && irr[i] && !rirr[i])));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irr    <= '0;
      pend   <= '0;
      rirr   <= '0;
      masked <= '1;
      lvl    <= '0;
      dsel   <= '0;
      tmr_on <= 1'b0;
      tmr    <= '0;
      for (int i = 0; i < NPINS; i++) begin
        vec[i]   <= '0;
        dest[i]  <= '0;
        dmod[i]  <= '0;
        storm[i] <= '0;
      end
    end else begin
      irr <= pin_level;
      for (int i = 0; i < NPINS; i++) begin
        if (wr_sel[i]) begin
          vec[i]    <= w_vec;
          dest[i]   <= w_dest;
          dmod[i]   <= w_del;
          dsel[i]   <= w_dsel;
          lvl[i]    <= w_lvl;
          masked[i] <= w_mask;
          rirr[i]   <= 1'b0;
          pend[i]   <= !w_mask && ((pend[i] && !issued[i]) || ev[i] || (w_lvl && irr[i]));
        end else begin
          if (issued[i] && lvl[i]) rirr[i] <= 1'b1;
          else if (eoi_hit[i])     rirr[i] <= 1'b0;
          pend[i] <= !masked[i] && ((pend[i] && !issued[i]) || ev[i]);
        end
        if (eoi_hit[i])
          storm[i] <= (eoi_retry[i] && !storm_hit[i]) ? storm[i] + CNT_W'(1) : '0;
      end
      if ((|storm_hit) && (!tmr_on || sweep)) begin
        tmr_on <= 1'b1;
        tmr    <= '0;
      end else if (sweep) begin
        tmr_on <= 1'b0;
      end else if (tmr_on) begin
        tmr <= tmr + TMR_W'(1);
      end
    end
  end

  assert_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid |-> !masked[dlv_pin]);

  assert_level_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && dlv_level) |-> !remote_irr[dlv_pin]);

  assert_rirr_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dlv_level && !(ent_wr && ent_pin == dlv_pin)) |=> remote_irr[$past(dlv_pin)]);

  assert_timer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_on |-> (tmr < TMR_W'(DEFER_CYCLES)));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dlv_valid && !dlv_ready && !ent_wr) |=> dlv_valid);

  for (genvar g = 0; g < NPINS; g++) begin : g_pin_chk
    assert_eoi_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_valid && lvl[g] && vec[g] == eoi_vector && !issued[g]) |=> !remote_irr[g]);
    assert_storm_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      storm[g] < CNT_W'(STORM_LIMIT));
  end

endmodule

// File: tb/tb_irq_pin_engine.sv
`timescale 1ns/100ps
module tb_irq_pin_engine;
  localparam int NP = 8;
  localparam int LIM = 4;
  localparam int DLY = 30;

  logic clk = 0, rst_n = 0;
  logic [NP-1:0] pin_level = '0;
  logic ent_wr = 0;
  logic [2:0] ent_pin = '0;
  logic [21:0] ent_data = '0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = '0;
  logic dlv_ready = 1;
  logic dlv_valid, dlv_dest_mode, dlv_level;
  logic [2:0] dlv_pin, dlv_del_mode;
  logic [7:0] dlv_vector, dlv_dest;
  logic [NP-1:0] remote_irr;

  always #2.5 clk = ~clk;

  irq_pin_engine #(.NPINS(NP), .VEC_W(8), .DEST_W(8), .STORM_LIMIT(LIM), .DEFER_CYCLES(DLY)) dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .ent_wr(ent_wr), .ent_pin(ent_pin),
    .ent_data(ent_data), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector), .dlv_valid(dlv_valid),
    .dlv_ready(dlv_ready), .dlv_pin(dlv_pin), .dlv_vector(dlv_vector), .dlv_dest(dlv_dest),
    .dlv_dest_mode(dlv_dest_mode), .dlv_del_mode(dlv_del_mode), .dlv_level(dlv_level),
    .remote_irr(remote_irr));

  typedef struct {
    int pin; logic [7:0] vec; logic [7:0] dest; logic lvl; logic dm; logic [2:0] del; string req;
  } exp_t;
  exp_t expq[$];
  int errors = 0, checks = 0;
  string cur_req = "R1";
  logic [7:0] b_vec [NP], b_dest [NP];
  logic b_lvl [NP], b_dm [NP];
  logic [2:0] b_del [NP];

  always @(negedge clk) begin
    if (rst_n && dlv_valid && dlv_ready) begin
      checks++;
      if (expq.size() == 0) begin
        errors++;
        $display("FAIL %s: unexpected delivery pin=%0d vec=%h, expected none", cur_req, dlv_pin, dlv_vector);
      end else begin
        exp_t e;
        e = expq.pop_front();
        if (dlv_pin != e.pin[2:0] || dlv_vector != e.vec || dlv_dest != e.dest ||
            dlv_level != e.lvl || dlv_dest_mode != e.dm || dlv_del_mode != e.del) begin
          errors++;
          $display("FAIL %s/R11: got pin=%0d vec=%h dest=%h lvl=%b dm=%b del=%0d expected pin=%0d vec=%h dest=%h lvl=%b dm=%b del=%0d",
                   e.req, dlv_pin, dlv_vector, dlv_dest, dlv_level, dlv_dest_mode, dlv_del_mode,
                   e.pin, e.vec, e.dest, e.lvl, e.dm, e.del);
        end
      end
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wr(int p, logic [7:0] v, logic [7:0] d, logic l, logic m, logic dm, logic [2:0] dl);
    b_vec[p] = v; b_dest[p] = d; b_lvl[p] = l; b_dm[p] = dm; b_del[p] = dl;
    ent_wr = 1; ent_pin = 3'(p); ent_data = {d, m, l, dm, dl, v};
    tick(1);
    ent_wr = 0;
  endtask

  task automatic eoi(logic [7:0] v);
    eoi_valid = 1; eoi_vector = v;
    tick(1);
    eoi_valid = 0;
  endtask

  task automatic want(int p, string req);
    exp_t e;
    e.pin = p; e.vec = b_vec[p]; e.dest = b_dest[p]; e.lvl = b_lvl[p];
    e.dm = b_dm[p]; e.del = b_del[p]; e.req = req;
    expq.push_back(e);
  endtask

  task automatic drained(string req);
    checks++;
    if (expq.size() != 0) begin
      errors++;
      $display("FAIL %s: %0d expected deliveries missing, expected 0", req, expq.size());
      expq.delete();
    end
  endtask

  task automatic chk(logic ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    chk(dlv_valid == 0, "R1", dlv_valid, 0);
    chk(remote_irr == 0, "R1", remote_irr, 0);
    pin_level[0] = 1; tick(4);
    drained("R1");
    pin_level[0] = 0;

    wr(1, 8'h31, 8'h11, 0, 0, 1, 3'd5);
    wr(2, 8'h42, 8'h22, 1, 0, 0, 3'd0);
    wr(3, 8'h43, 8'h33, 1, 0, 0, 3'd1);
    wr(5, 8'h55, 8'h55, 0, 1, 0, 3'd0);

    cur_req = "R2";
    want(1, "R2"); pin_level[1] = 1; tick(6);
    drained("R2");
    pin_level[1] = 0; tick(1);
    dlv_ready = 0;
    pin_level[1] = 1; tick(1); pin_level[1] = 0; tick(1); pin_level[1] = 1; tick(1);
    want(1, "R2"); dlv_ready = 1; tick(5);
    drained("R2");
    pin_level[1] = 0; tick(1);

    cur_req = "R3";
    pin_level[5] = 1; tick(5);
    drained("R3");

    cur_req = "R10";
    dlv_ready = 0;
    pin_level[1] = 1; pin_level[2] = 1; pin_level[3] = 1; tick(1);
    chk(dlv_valid && dlv_pin == 1, "R10", dlv_pin, 1);
    tick(3);
    chk(dlv_valid && dlv_pin == 1, "R10", dlv_pin, 1);
    want(1, "R10"); want(2, "R10"); want(3, "R10");
    dlv_ready = 1; tick(6);
    drained("R10");
    chk(remote_irr[3:2] == 2'b11, "R4", remote_irr[3:2], 3);

    cur_req = "R5";
    pin_level[2] = 0; tick(2); pin_level[2] = 1; tick(5);
    drained("R5");
    chk(remote_irr[2] == 1, "R5", remote_irr[2], 1);

    cur_req = "R6";
    want(3, "R6"); eoi(8'h43); tick(4);
    drained("R6");
    chk(remote_irr[3] == 1, "R6", remote_irr[3], 1);
    pin_level[2] = 0; tick(2);
    eoi(8'h42); tick(4);
    drained("R6");
    chk(remote_irr[2] == 0, "R6", remote_irr[2], 0);
    eoi(8'h99); tick(3);
    chk(remote_irr[3] == 1, "R6", remote_irr[3], 1);
    eoi(8'h31); tick(3);
    drained("R6");

    cur_req = "R7";
    for (int k = 0; k < LIM - 2; k++) begin
      want(3, "R7"); eoi(8'h43); tick(4);
    end
    drained("R7");
    eoi(8'h43);
    chk(remote_irr[3] == 0, "R7", remote_irr[3], 0);
    cur_req = "R8";
    tick(DLY - 2);
    chk(dlv_valid == 0, "R8", dlv_valid, 0);
    want(3, "R8"); tick(5);
    drained("R8");

    cur_req = "R7";
    want(3, "R7"); eoi(8'h43); tick(3);
    want(3, "R7"); eoi(8'h43); tick(3);
    pin_level[3] = 0; tick(2);
    eoi(8'h43); tick(3);
    drained("R7");
    want(3, "R4"); pin_level[3] = 1; tick(4);
    drained("R4");
    for (int k = 0; k < LIM - 1; k++) begin
      want(3, "R7"); eoi(8'h43); tick(4);
    end
    drained("R7");
    eoi(8'h43);
    cur_req = "R8";
    tick(DLY - 2);
    chk(dlv_valid == 0, "R8", dlv_valid, 0);
    want(3, "R8"); tick(5);
    drained("R8");

    cur_req = "R9";
    wr(3, 8'h63, 8'h36, 1, 0, 1, 3'd2);
    want(3, "R9"); tick(4);
    drained("R9");
    chk(remote_irr[3] == 1, "R9", remote_irr[3], 1);
    wr(2, 8'h52, 8'h25, 1, 0, 0, 3'd0); tick(4);
    drained("R9");

    cur_req = "R3";
    pin_level[1] = 0; tick(2);
    dlv_ready = 0;
    pin_level[1] = 1; tick(1);
    chk(dlv_valid == 1, "R3", dlv_valid, 1);
    wr(1, 8'h31, 8'h11, 0, 1, 1, 3'd5);
    dlv_ready = 1; tick(4);
    drained("R3");
    chk(dlv_valid == 0, "R3", dlv_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule